// File: doc/BRIEF.md
# NRZI Receive Decoder with Bit Destuffing

This block sits behind a line sampler on a two-wire serial bus. Each time the sampler strobes a line state (idle-level J, opposite-level K, both-low SE0, or the illegal both-high SE1), the block frames it. While idle it waits for a K, which marks the start of a packet. During reception it turns each J or K into a data bit by NRZI rules: no change of line state is a 1, a change is a 0. After a run of consecutive 1s it removes the inserted 0 that the transmitter placed there, and it aborts the packet if that bit is a 1 instead.

A sampled SE0 begins the end-of-packet sequence. The first J after it closes the packet. Every framing event appears as a one-clock pulse. The level output `rx_idle` tells the sampler when the framer has gone back to idle, so the sampler can start its search for the next start edge. Byte assembly, sync-pattern checking, packet identifiers and CRC are handled by later stages.

Top module: `nrzi_destuff_rx`

## Requirements
- R1: In idle, a valid sample of K (`sym`=2'b10) gives a `sop_p` pulse and starts reception. A valid sample of J (2'b01), SE0 (2'b00) or SE1 (2'b11) in idle gives no output pulse and leaves `rx_idle` high.
- R2: During reception, a valid J or K that equals the previous line state gives `bit_vld` with `bit_val`=1. One that differs gives `bit_val`=0. The previous state is set to J at start of packet, so a first K decodes as 0.
- R3: The run of consecutive 1s is cleared at start of packet and on every decoded 0. When the run has reached STUFF_RUN (default 6), the next J/K is a stuff bit. If it decodes as 0, it produces a `stuff_p` pulse and no `bit_vld`, and the run is cleared.
- R4: If the J/K after STUFF_RUN consecutive 1s decodes as 1, `err_p` pulses and the block returns to idle.
- R5: A valid SE0 during reception produces no data bit and enters end-of-packet handling. Further SE0 samples stay in that handling and produce no pulse.
- R6: In end-of-packet handling, a valid J gives an `eop_p` pulse and returns to idle, with no data bit.
- R7: A valid SE1 during reception, or a valid K or SE1 during end-of-packet handling, gives an `err_p` pulse and returns to idle.
- R8: After reset, `rx_idle` is 1 and all pulse outputs are 0. `rx_idle` is 1 exactly when the framer is idle.
- R9: The result of a sample appears on the outputs one clock after the cycle in which `sym_vld` is high. Every pulse lasts one clock. At most one of `sop_p`, `eop_p`, `err_p`, `stuff_p`, `bit_vld` is high in any cycle. None is high one clock after a cycle without `sym_vld`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sym_vld | input | 1 | Strobe: `sym` holds a new mid-bit sample |
| sym | input | 2 | Line state: 00 SE0, 01 J, 10 K, 11 SE1 |
| sop_p | output | 1 | Start-of-packet pulse |
| eop_p | output | 1 | End-of-packet pulse |
| err_p | output | 1 | Stuffing or framing error pulse |
| stuff_p | output | 1 | Stuff bit removed pulse |
| bit_vld | output | 1 | Decoded data bit strobe |
| bit_val | output | 1 | Decoded data bit, meaningful with `bit_vld` |
| rx_idle | output | 1 | Framer idle; sampler may search for start |

## Verification
A start pattern of alternating K and J, followed by repeated line states, separates the 0 decode from the 1 decode. It also shows that the first K after start of packet counts against J. Runs of exactly six 1s followed by a change, by no change, or by a break of five 1s and a 0 tell a correct destuff apart from an error abort and from a run counter that fails to clear. SE0 streams ending in J, K or SE1, and SE1 in mid-packet, cover each exit of end-of-packet handling. A long seeded random stream with random gaps between strobes checks the quiet cycles between samples against the same bench model.

// File: rtl/nrzi_pkg.sv
package nrzi_pkg;

   typedef enum logic [1:0] {
      LN_SE0 = 2'b00,
      LN_J   = 2'b01,
      LN_K   = 2'b10,
      LN_SE1 = 2'b11
   } line_t;

   typedef enum logic [1:0] {
      FR_IDLE = 2'd0,
      FR_DATA = 2'd1,
      FR_EOP  = 2'd2
   } frame_t;

   typedef struct packed {
      logic sop;
      logic eop;
      logic err;
      logic stuff;
      logic bit_vld;
      logic bit_val;
   } evt_t;

endpackage

// File: rtl/nrzi_run_counter.sv
module nrzi_run_counter #(
   parameter int RUN   = 6,
   parameter int CNT_W = $clog2(RUN + 1)
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   input  logic inc,
   output logic full
);
   localparam logic [CNT_W-1:0] RUN_C = CNT_W'(RUN);

   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt <= '0;
      else if (clr)
         cnt <= '0;
      else if (inc && cnt != RUN_C)
         cnt <= cnt + 1'b1;
   end

   assign full = (cnt == RUN_C);

endmodule

// File: rtl/nrzi_frame_fsm.sv
module nrzi_frame_fsm
   import nrzi_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sym_vld,
   input  logic [1:0] sym_i,
   input  logic       run_full,
   output logic       run_clr,
   output logic       run_inc,
   output evt_t       evt,
   output logic       in_idle
);
   frame_t state, state_nxt;
   line_t  prev, prev_nxt;
   line_t  line;
   logic   same;

   assign line = line_t'(sym_i);
   assign same = (line == prev);

   always_comb begin
      state_nxt = state;
      prev_nxt  = prev;
      evt       = '0;
      run_clr   = 1'b0;
      run_inc   = 1'b0;
      if (sym_vld) begin
         case (state)
            FR_IDLE: begin
               if (line == LN_K) begin
                  evt.sop   = 1'b1;
                  state_nxt = FR_DATA;
                  run_clr   = 1'b1;
               end
            end
            FR_DATA: begin
               case (line)
                  LN_SE0: state_nxt = FR_EOP;
                  LN_SE1: begin
                     evt.err   = 1'b1;
                     state_nxt = FR_IDLE;
                  end
                  default: begin
                     prev_nxt = line;
                     if (run_full) begin
                        if (!same) begin
                           evt.stuff = 1'b1;
                           run_clr   = 1'b1;
                        end else begin
                           evt.err   = 1'b1;
                           state_nxt = FR_IDLE;
                        end
                     end else begin
                        evt.bit_vld = 1'b1;
                        evt.bit_val = same;
                        run_inc     = same;
                        run_clr     = !same;
                     end
                  end
               endcase
            end
            FR_EOP: begin
               if (line == LN_J) begin
                  evt.eop   = 1'b1;
                  state_nxt = FR_IDLE;
               end else if (line != LN_SE0) begin
                  evt.err   = 1'b1;
                  state_nxt = FR_IDLE;
               end
            end
            default: state_nxt = FR_IDLE;
         endcase
      end
      if (state_nxt == FR_IDLE)
         prev_nxt = LN_J;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= FR_IDLE;
         prev  <= LN_J;
      end else begin
         state <= state_nxt;
         prev  <= prev_nxt;
      end
   end

   assign in_idle = (state == FR_IDLE);

endmodule

// File: rtl/nrzi_evt_out.sv
module nrzi_evt_out
   import nrzi_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  evt_t evt_d,
   output evt_t evt_q
);
   generate
      if (OUT_REG) begin : g_reg
         always_ff @(posedge clk) begin
            if (!rst_n)
               evt_q <= '0;
            else
               evt_q <= evt_d;
         end
      end else begin : g_comb
         logic unused_clk;
         assign unused_clk = clk ^ rst_n;
         assign evt_q = evt_d;
      end
   endgenerate

endmodule

// File: rtl/nrzi_destuff_rx.sv
module nrzi_destuff_rx
   import nrzi_pkg::*;
#(
   parameter int STUFF_RUN = 6,
   parameter bit OUT_REG   = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       sym_vld,
   input  logic [1:0] sym,
   output logic       sop_p,
   output logic       eop_p,
   output logic       err_p,
   output logic       stuff_p,
   output logic       bit_vld,
   output logic       bit_val,
   output logic       rx_idle
);
   localparam int CNT_W = $clog2(STUFF_RUN + 1);

   generate
      if (STUFF_RUN < 1 || STUFF_RUN > 64) begin : g_bad_run
         $error("STUFF_RUN must lie in 1..64");
      end
   endgenerate

   logic run_clr, run_inc, run_full;
   evt_t evt_d, evt_q;

   nrzi_run_counter #(
      .RUN   (STUFF_RUN),
      .CNT_W (CNT_W)
   ) run_i (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (run_clr),
      .inc   (run_inc),
      .full  (run_full)
   );

   nrzi_frame_fsm fsm_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sym_vld  (sym_vld),
      .sym_i    (sym),
      .run_full (run_full),
      .run_clr  (run_clr),
      .run_inc  (run_inc),
      .evt      (evt_d),
      .in_idle  (rx_idle)
   );

   nrzi_evt_out #(
      .OUT_REG (OUT_REG)
   ) out_i (
      .clk   (clk),
      .rst_n (rst_n),
      .evt_d (evt_d),
      .evt_q (evt_q)
   );

   assign sop_p   = evt_q.sop;
   assign eop_p   = evt_q.eop;
   assign err_p   = evt_q.err;
   assign stuff_p = evt_q.stuff;
   assign bit_vld = evt_q.bit_vld;
   assign bit_val = evt_q.bit_val;

endmodule

// File: rtl/nrzi_destuff_rx_chk.sv
module nrzi_destuff_rx_chk #(
   parameter bit OUT_REG = 1'b1
) (
   input logic       clk,
   input logic       rst_n,
   input logic       sym_vld,
   input logic [1:0] sym,
   input logic       sop_p,
   input logic       eop_p,
   input logic       err_p,
   input logic       stuff_p,
   input logic       bit_vld,
   input logic       rx_idle
);
   AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sop_p, eop_p, err_p, stuff_p, bit_vld})); // R9

   AST_ERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      err_p |-> rx_idle); // R7

   AST_EOP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      eop_p |-> rx_idle); // R6

   AST_SOP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      (sop_p || stuff_p || bit_vld) |-> !rx_idle); // R8

   generate
      if (OUT_REG) begin : g_timed
         AST_QUIET_NO_VLD: assert property (@(posedge clk) disable iff (!rst_n)
            !sym_vld |=> !(sop_p || eop_p || err_p || stuff_p || bit_vld)); // R9

         AST_SOP_FROM_K: assert property (@(posedge clk) disable iff (!rst_n)
            sop_p |-> ($past(rx_idle) && $past(sym) == 2'b10)); // R1

         AST_BIT_FROM_JK: assert property (@(posedge clk) disable iff (!rst_n)
            bit_vld |-> ($past(sym) == 2'b01 || $past(sym) == 2'b10)); // R2

         AST_EOP_FROM_J: assert property (@(posedge clk) disable iff (!rst_n)
            eop_p |-> ($past(sym) == 2'b01 && !$past(rx_idle))); // R6

         AST_SE0_NO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            (sym_vld && sym == 2'b00) |=> !(sop_p || eop_p || err_p || stuff_p || bit_vld)); // R5
      end
   endgenerate

endmodule

bind nrzi_destuff_rx nrzi_destuff_rx_chk #(.OUT_REG(OUT_REG)) chk_i (
   .clk     (clk),
   .rst_n   (rst_n),
   .sym_vld (sym_vld),
   .sym     (sym),
   .sop_p   (sop_p),
   .eop_p   (eop_p),
   .err_p   (err_p),
   .stuff_p (stuff_p),
   .bit_vld (bit_vld),
   .rx_idle (rx_idle)
);

// File: tb/nrzi_destuff_rx_tb_top.sv
module nrzi_destuff_rx_tb_top;
   localparam logic [1:0] SE0 = 2'b00, JJ = 2'b01, KK = 2'b10, SE1 = 2'b11;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sym_vld = 1'b0;
   logic [1:0] sym = JJ;
   logic sop_p, eop_p, err_p, stuff_p, bit_vld, bit_val, rx_idle;

   int total = 0;
   int bad = 0;

   int m_state = 0;
   logic [1:0] m_prev = JJ;
   int m_ones = 0;

   always #2.5 clk = ~clk;

   nrzi_destuff_rx dut_i (
      .clk(clk), .rst_n(rst_n), .sym_vld(sym_vld), .sym(sym),
      .sop_p(sop_p), .eop_p(eop_p), .err_p(err_p), .stuff_p(stuff_p),
      .bit_vld(bit_vld), .bit_val(bit_val), .rx_idle(rx_idle)
   );

   function automatic logic [6:0] actual_vec();
      return {sop_p, eop_p, err_p, stuff_p, bit_vld, bit_val & bit_vld, rx_idle};
   endfunction

   task automatic check(input logic [6:0] act, input logic [6:0] exp, input string tag);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s: outputs {sop,eop,err,stuff,vld,bit,idle} actual=%b expected=%b", tag, act, exp);
      end
   endtask

   task automatic model(input logic [1:0] s, output logic [6:0] exp, output string tag);
      logic one;
      exp = 7'b0;
      tag = "R1";
      case (m_state)
         0: if (s == KK) begin
               exp[6] = 1'b1; m_state = 1; m_prev = JJ; m_ones = 0;
            end
         1: if (s == SE0) begin
               m_state = 2; tag = "R5";
            end else if (s == SE1) begin
               exp[4] = 1'b1; m_state = 0; tag = "R7";
            end else begin
               one = (s == m_prev);
               m_prev = s;
               if (m_ones == 6) begin
                  if (!one) begin exp[3] = 1'b1; m_ones = 0; tag = "R3"; end
                  else begin exp[4] = 1'b1; m_state = 0; tag = "R4"; end
               end else begin
                  exp[2] = 1'b1; exp[1] = one; tag = "R2";
                  m_ones = one ? m_ones + 1 : 0;
               end
            end
         default: if (s == SE0) tag = "R5";
            else if (s == JJ) begin exp[5] = 1'b1; m_state = 0; tag = "R6"; end
            else begin exp[4] = 1'b1; m_state = 0; tag = "R7"; end
      endcase
      if (m_state == 0) m_prev = JJ;
      exp[0] = (m_state == 0);
   endtask

   task automatic send(input logic [1:0] s, input int gap);
      logic [6:0] exp;
      string tag;
      @(negedge clk);
      sym_vld = 1'b1;
      sym = s;
      model(s, exp, tag);
      @(posedge clk);
      #1;
      check(actual_vec(), exp, tag);
      for (int g = 0; g < gap; g++) begin
         @(negedge clk);
         sym_vld = 1'b0;
         sym = 2'($urandom_range(0, 3));
         @(posedge clk);
         #1;
         check(actual_vec(), {6'b0, exp[0]}, "R9");
      end
   endtask

   task automatic send_run(input logic [1:0] s, input int n);
      for (int i = 0; i < n; i++) send(s, i % 2);
   endtask

   initial begin
      #(5.0 * 150000);
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd7));
      repeat (3) @(posedge clk);
      #1;
      check(actual_vec(), 7'b0000001, "R8");
      @(negedge clk);
      rst_n = 1'b1;

      // R1: idle ignores J, SE0, SE1
      send(JJ, 1); send(SE0, 0); send(SE1, 1); send(JJ, 1);
      // R2: start pattern then end of packet (R5, R6)
      send(KK, 0);
      send(JJ, 0); send(KK, 0); send(JJ, 0); send(KK, 1); send(KK, 0); send(JJ, 0);
      send(SE0, 1); send(SE0, 0); send(JJ, 1);
      // R3: six ones then change is a stuff bit, twice in a row
      send(KK, 0); send_run(JJ, 6); send(KK, 0); send_run(KK, 6); send(JJ, 0);
      send(JJ, 0); send(SE0, 0); send(JJ, 1);
      // R3: five ones then a zero clears the run
      send(KK, 0); send_run(JJ, 5); send(KK, 0); send_run(KK, 6); send(JJ, 1);
      send(SE0, 0); send(JJ, 1);
      // R4: seventh one aborts
      send(KK, 0); send_run(JJ, 6); send(JJ, 1); send(KK, 1);
      // R7: SE1 in data (K already started a packet)
      send(SE1, 1);
      // R7: K and SE1 during end of packet
      send(KK, 0); send(KK, 0); send(SE0, 0); send(KK, 1);
      send(KK, 0); send(SE0, 0); send(SE0, 0); send(SE1, 1);

      // seeded random stream
      for (int n = 0; n < 4000; n++) begin
         int r;
         logic [1:0] s;
         r = $urandom_range(0, 99);
         if (r < 44) s = JJ;
         else if (r < 88) s = KK;
         else if (r < 97) s = SE0;
         else s = SE1;
         send(s, $urandom_range(0, 2));
      end
      send(SE0, 1);
      send(JJ, 1);

      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule